// File: doc/BRIEF.md
# Dual-Register Programmable Logic Macrocell

This block is one output cell of a small programmable logic device. It receives the evaluated product-term bits from the AND array, plus a dedicated clock pin, a shared synchronous preset line and a static configuration word. From these it computes the pin value, the output enable, and two feedback signals that return to the array.

Twelve product terms are ORed in groups of four to form three sum terms. Those sums are then distributed to two flip-flops. Each flip-flop can be D or T type. Each has its own clock term, which may be gated by the clock pin, and its own level-sensitive asynchronous reset term. The pin shows either register 1 or the combinatorial sum feeding it, with selectable polarity. The buried feedback shows either register 2 or its input.

Product-term clocks are treated as signals sampled by the system clock `clk`. A register acts when the sampled level of its clock source goes from 0 to 1. The configuration is changed only while `init` is high.

Top module: `pld_macrocell`

## Requirements
- R1: The sum terms are `sum0 = |pt[3:0]`, `sum1 = |pt[7:4]` and `sum2 = |pt[11:8]`. The allocation field `cfg[6:5]` selects the register-1 input `d1` and the register-2 input `d2` as follows:
  - 0: `d1 = sum0`, `d2 = sum2`
  - 1: `d1 = sum0|sum1`, `d2 = sum2`
  - 2: `d1 = sum0|sum1|sum2`, `d2 = sum2`
  - 3: `d1 = sum0`, `d2 = sum1|sum2`

  When `cfg[4]=1` (combinatorial output), the pin follows `d1` through the polarity stage within the same cycle.
- R2: When `cfg[7]=1` the pin shows the raw output value. When `cfg[7]=0` the pin shows its inverse.
- R3: When `cfg[4]=0` the pin shows register 1. A register changes only on a system clock edge at which its clock source is 1 and was 0 at the previous edge. A D-type register (`cfg[0]` for register 1, `cfg[1]` for register 2, value 0) then loads its input.
- R4: A T-type register (type bit 1) inverts its state on such an edge when its input is 1, and holds its state when the input is 0.
- R5: The clock source of register 1 is `pt[13]`, and of register 2 is `pt[14]`. When the gating bit is set (`cfg[2]` for register 1, `cfg[3]` for register 2), the source is that term ANDed with `clkPin`. Otherwise it is the term alone.
- R6: `pt[12]` clears register 1 and `pt[15]` clears register 2 at once and for as long as the term is 1. Reset overrides clocking and preset, and each reset term leaves the other register untouched.
- R7: When `presetIn` is 1 at a register's clock edge, that register becomes 1 whatever its type and input.
- R8: `fbReg1` always shows register 1. `fbBuried` shows register 2 when `cfg[8]=0`, and `d2` when `cfg[8]=1`.
- R9: While `init` is high, both registers and the clock-edge history are 0. In registered mode, the pin then reads the inverse of `cfg[7]`.
- R10: `outEn` equals `pt[16]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all clock sources |
| init | input | 1 | Power-up initialisation, active high, asynchronous |
| pt | input | 17 | Evaluated product terms: [11:0] sums, 12 reset1, 13 clock1, 14 clock2, 15 reset2, 16 output enable |
| clkPin | input | 1 | Dedicated clock pin level |
| presetIn | input | 1 | Shared synchronous preset line |
| cfg | input | 9 | Static configuration word (fields given in R1 to R8) |
| pinOut | output | 1 | Value driven toward the pin |
| outEn | output | 1 | Output enable toward the pin buffer |
| fbReg1 | output | 1 | Register 1 feedback to the array |
| fbBuried | output | 1 | Buried feedback: register 2 or its input |

## Verification
The bench builds the cell with its default of three sum terms of four product terms each. With that setting, every one of the 512 configuration words can be swept exhaustively rather than sampled. Each word is run with biased random product terms, so every allocation, clock gating, register type, polarity and feedback choice meets resets, presets and back-to-back clock pulses. The four-term grouping keeps sum terms near a 50 percent density, which makes the distinctions between allocation modes observable.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef struct packed {
    logic       fbBypass;
    logic       activeHigh;
    logic [1:0] alloc;
    logic       outComb;
    logic       pinClk2;
    logic       pinClk1;
    logic       tType2;
    logic       tType1;
  } mcCfg_t;

  localparam int CFG_W = $bits(mcCfg_t);

  typedef struct packed {
    logic arst1;
    logic arst2;
    logic tick1;
    logic tick2;
    logic preset;
  } mcStrobe_t;

endpackage

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic clk,
  input  logic arst,
  input  logic tick,
  input  logic preset,
  input  logic tType,
  input  logic dIn,
  output logic q
);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)
      q <= 1'b0;
    else if (tick) begin
      if (preset)
        q <= 1'b1;
      else if (tType)
        q <= q ^ dIn;
      else
        q <= dIn;
    end
  end

  assert_reset_clear_R6: assert property (@(posedge clk) arst |-> (q == 1'b0));

  assert_hold_no_edge_R3: assert property (@(posedge clk) disable iff (arst)
    !tick |=> $stable(q));

  assert_preset_high_R7: assert property (@(posedge clk) disable iff (arst)
    (tick && preset) |=> q);

  assert_toggle_rule_R4: assert property (@(posedge clk) disable iff (arst)
    (tick && !preset && tType) |=> ((q != $past(q)) == $past(dIn)));

endmodule

// File: rtl/mc_control.sv
module mc_control
  import pld_mc_pkg::*;
(
  input  logic       clk,
  input  logic       init,
  input  logic [1:0] ckTerm,
  input  logic [1:0] arTerm,
  input  logic [1:0] pinGate,
  input  logic       clkPin,
  input  logic       presetIn,
  output mcStrobe_t  strb
);

  logic [1:0] clkSrc;
  logic [1:0] prevLvl;
  logic [1:0] tickVec;

  for (genvar g = 0; g < 2; g++) begin : gen_src
    assign clkSrc[g]  = ckTerm[g] & (pinGate[g] ? clkPin : 1'b1);
    assign tickVec[g] = clkSrc[g] & ~prevLvl[g];
  end

  always_ff @(posedge clk or posedge init) begin
    if (init)
      prevLvl <= '0;
    else
      prevLvl <= clkSrc;
  end

  always_comb begin
    strb.arst1  = init | arTerm[0];
    strb.arst2  = init | arTerm[1];
    strb.tick1  = tickVec[0];
    strb.tick2  = tickVec[1];
    strb.preset = presetIn;
  end

  assert_single_tick_R5: assert property (@(posedge clk) disable iff (init)
    strb.tick1 |=> !strb.tick1);

  assert_single_tick2_R5: assert property (@(posedge clk) disable iff (init)
    strb.tick2 |=> !strb.tick2);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import pld_mc_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  parameter int NUM_SUMS      = 3,
  localparam int ARRAY_W      = TERMS_PER_SUM * NUM_SUMS
) (
  input  logic               clk,
  input  logic [ARRAY_W-1:0] sumTerms,
  input  logic               oeTerm,
  input  mcCfg_t             cfg,
  input  mcStrobe_t          strb,
  output logic               pinOut,
  output logic               outEn,
  output logic               fbReg1,
  output logic               fbBuried
);

  logic [NUM_SUMS-1:0] sumVec;
  logic [1:0] dVec, qVec, arstVec, tickVec, tSel;
  logic rawOut;

  for (genvar s = 0; s < NUM_SUMS; s++) begin : gen_sum
    assign sumVec[s] = |sumTerms[s*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  always_comb begin
    unique case (cfg.alloc)
      2'd0: dVec = {sumVec[NUM_SUMS-1], sumVec[0]};
      2'd1: dVec = {sumVec[NUM_SUMS-1], sumVec[0] | sumVec[1]};
      2'd2: dVec = {sumVec[NUM_SUMS-1], |sumVec};
      2'd3: dVec = {sumVec[1] | sumVec[NUM_SUMS-1], sumVec[0]};
    endcase
  end

  assign arstVec = {strb.arst2, strb.arst1};
  assign tickVec = {strb.tick2, strb.tick1};
  assign tSel    = {cfg.tType2, cfg.tType1};

  for (genvar g = 0; g < 2; g++) begin : gen_reg
    mc_reg u_reg (
      .clk   (clk),
      .arst  (arstVec[g]),
      .tick  (tickVec[g]),
      .preset(strb.preset),
      .tType (tSel[g]),
      .dIn   (dVec[g]),
      .q     (qVec[g])
    );
  end

  assign rawOut   = cfg.outComb ? dVec[0] : qVec[0];
  assign pinOut   = cfg.activeHigh ? rawOut : ~rawOut;
  assign outEn    = oeTerm;
  assign fbReg1   = qVec[0];
  assign fbBuried = cfg.fbBypass ? dVec[1] : qVec[1];

  assert_init_pin_level_R9: assert property (@(posedge clk)
    (strb.arst1 && !cfg.outComb) |-> (pinOut == !cfg.activeHigh));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  parameter int NUM_SUMS      = 3,
  localparam int ARRAY_W      = TERMS_PER_SUM * NUM_SUMS,
  localparam int PT_W         = ARRAY_W + 5
) (
  input  logic             clk,
  input  logic             init,
  input  logic [PT_W-1:0]  pt,
  input  logic             clkPin,
  input  logic             presetIn,
  input  logic [CFG_W-1:0] cfg,
  output logic             pinOut,
  output logic             outEn,
  output logic             fbReg1,
  output logic             fbBuried
);

  localparam int IDX_AR1 = ARRAY_W;
  localparam int IDX_CK1 = ARRAY_W + 1;
  localparam int IDX_CK2 = ARRAY_W + 2;
  localparam int IDX_AR2 = ARRAY_W + 3;
  localparam int IDX_OE  = ARRAY_W + 4;

  mcCfg_t    cfgS;
  mcStrobe_t strb;

  assign cfgS = mcCfg_t'(cfg);

  mc_control u_control (
    .clk     (clk),
    .init    (init),
    .ckTerm  ({pt[IDX_CK2], pt[IDX_CK1]}),
    .arTerm  ({pt[IDX_AR2], pt[IDX_AR1]}),
    .pinGate ({cfgS.pinClk2, cfgS.pinClk1}),
    .clkPin  (clkPin),
    .presetIn(presetIn),
    .strb    (strb)
  );

  mc_datapath #(
    .TERMS_PER_SUM(TERMS_PER_SUM),
    .NUM_SUMS     (NUM_SUMS)
  ) u_datapath (
    .clk     (clk),
    .sumTerms(pt[ARRAY_W-1:0]),
    .oeTerm  (pt[IDX_OE]),
    .cfg     (cfgS),
    .strb    (strb),
    .pinOut  (pinOut),
    .outEn   (outEn),
    .fbReg1  (fbReg1),
    .fbBuried(fbBuried)
  );

endmodule

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PT_W = 17;
  localparam int CFG_W = 9;
  localparam int CYCLES_PER_CFG = 40;

  logic clk = 1'b0;
  logic init = 1'b0;
  logic [PT_W-1:0] pt = '0;
  logic clkPin = 1'b0;
  logic presetIn = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic pinOut, outEn, fbReg1, fbBuried;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic mq1, mq2, mp1, mp2;
  string ev1 = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_macrocell u_pld_macrocell (
    .clk(clk), .init(init), .pt(pt), .clkPin(clkPin), .presetIn(presetIn),
    .cfg(cfg), .pinOut(pinOut), .outEn(outEn), .fbReg1(fbReg1), .fbBuried(fbBuried)
  );

  // returns {d2, d1} per R1
  function automatic logic [1:0] dataOf(logic [CFG_W-1:0] c, logic [PT_W-1:0] p);
    logic a, b, s2;
    a  = |p[3:0];
    b  = |p[7:4];
    s2 = |p[11:8];
    case (c[6:5])
      2'd0: return {s2, a};
      2'd1: return {s2, a | b};
      2'd2: return {s2, a | b | s2};
      default: return {b | s2, a};
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    logic [1:0] d;
    logic raw, expPin;
    string tag;
    d = dataOf(cfg, pt);
    raw = cfg[4] ? d[0] : mq1;
    expPin = cfg[7] ? raw : ~raw;
    tag = cfg[4] ? (cfg[7] ? "R1" : "R2") : ev1;
    check(tag, "pinOut", pinOut, expPin);
    check("R10", "outEn", outEn, pt[16]);
    check("R8", "fbReg1", fbReg1, mq1);
    check("R8", "fbBuried", fbBuried, cfg[8] ? d[1] : mq2);
  endtask

  // model of one register at a system clock edge (R3..R7)
  task automatic modelEdge();
    logic [1:0] d;
    logic src1, src2, tk1, tk2;
    d = dataOf(cfg, pt);
    src1 = pt[13] & (cfg[2] ? clkPin : 1'b1);
    src2 = pt[14] & (cfg[3] ? clkPin : 1'b1);
    tk1 = src1 & ~mp1;
    tk2 = src2 & ~mp2;
    mp1 = src1;
    mp2 = src2;
    if (pt[12]) begin
      mq1 = 1'b0; ev1 = "R6";
    end else if (tk1) begin
      if (presetIn) begin mq1 = 1'b1; ev1 = "R7"; end
      else if (cfg[0]) begin mq1 = mq1 ^ d[0]; ev1 = "R4"; end
      else begin mq1 = d[0]; ev1 = cfg[2] ? "R5" : "R3"; end
    end else
      ev1 = cfg[2] ? "R5" : "R3";
    if (pt[15]) mq2 = 1'b0;
    else if (tk2) begin
      if (presetIn) mq2 = 1'b1;
      else if (cfg[1]) mq2 = mq2 ^ d[1];
      else mq2 = d[1];
    end
  endtask

  task automatic randomCycle();
    logic [PT_W-1:0] p;
    @(negedge clk);
    p[11:0] = 12'($urandom & $urandom & $urandom);
    p[12] = (($urandom % 16) == 0);
    p[13] = 1'($urandom);
    p[14] = 1'($urandom);
    p[15] = (($urandom % 16) == 0);
    p[16] = 1'($urandom);
    pt = p;
    clkPin = 1'($urandom);
    presetIn = (($urandom % 8) == 0);
    #1;
    if (pt[12]) begin mq1 = 1'b0; ev1 = "R6"; end
    if (pt[15]) mq2 = 1'b0;
    checkOutputs();
    @(posedge clk);
    modelEdge();
  endtask

  initial begin
    void'($urandom(32'h5EED_2500));
    #1;
    for (int c = 0; c < (1 << CFG_W); c++) begin
      @(negedge clk);
      init = 1'b1;
      cfg = CFG_W'(c);
      pt = '0;
      clkPin = 1'b0;
      presetIn = 1'b0;
      mq1 = 0; mq2 = 0; mp1 = 0; mp2 = 0;
      #1;
      // R9: reset state, pin level set by polarity in registered mode
      check("R9", "fbReg1", fbReg1, 1'b0);
      check("R9", "fbBuried", fbBuried, 1'b0);
      if (!cfg[4]) check("R9", "pinOut", pinOut, ~cfg[7]);
      @(negedge clk);
      init = 1'b0;
      ev1 = "R3";
      for (int k = 0; k < CYCLES_PER_CFG; k++) randomCycle();
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule